// File: doc/BRIEF.md
# Coalescing Completion Interrupt Controller

This block produces one level-sensitive host interrupt line from two streams of completion pulses, one from the receive path and one from the send path. It does not raise the line on every completion. Each path opens a coalescing window on its first completion after the previous interrupt. The window closes, and an interrupt becomes pending, when either the path's tick counter reaches its tick threshold or its completion counter reaches its count threshold. A free-running tick strobe from elsewhere in the chip drives the tick counters.

Software controls the block through a small word-addressed register port with combinational read-back. The port holds the four thresholds, an option word, a mask register, a host mailbox word and a host-control word. Three independent paths hold the line low while pending state is kept: a mask bit in host control, the mask register, and a nonzero mailbox value. Pending state is cleared either by writing 1 to the clear bit of host control or by any write to the mailbox. A host handler usually writes a nonzero mailbox value on entry and zero on exit.

Top module: `coal_irq_ctrl`

## Requirements
- R1: After reset the interrupt is low and reads give: address 3 (receive tick threshold) = 120, address 4 (send tick threshold) = 400, address 5 (receive count threshold) = 25, address 6 (send count threshold) = 60, address 0 (host control) = 0, address 2 (mailbox) = 0.
- R2: With a nonzero receive count threshold N, the interrupt becomes pending at the clock edge that samples the Nth receive completion of a window and not before.
- R3: Tick strobes are counted only while a path's window is open. With a nonzero tick threshold T, the interrupt becomes pending at the edge that samples the Tth tick after the window opened.
- R4: A threshold of zero disables that trigger for that path. With both of its thresholds zero, a path never raises the interrupt, however many completions and ticks arrive.
- R5: When bit 0 of the option word (address 7) is 1, the send count trigger is ignored and send completions cause an interrupt only through the send tick threshold. When the bit is 0, the send count threshold applies.
- R6: Host-control bit 2 (address 0) masks the output while set. Pending state is kept, and the line rises once the bit is cleared.
- R7: Bit 0 of the mask register (address 1) masks the output while set. Pending state is kept, and the line rises once the bit is cleared.
- R8: A nonzero mailbox value (address 2) holds the output low.
- R9: Any write to the mailbox clears the pending interrupt, whatever value is written.
- R10: Writing 1 to host-control bit 1 clears the pending interrupt. Host-control bit 0 is read-only and shows the pending state before masking; writing it has no effect.
- R11: If a path fires in the same cycle as a clear (host-control bit 1 or a mailbox write), the interrupt stays pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Free-running coalescing tick strobe |
| tx_done_i | input | 1 | Send completion pulse |
| rx_done_i | input | 1 | Receive completion pulse |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| irq_o | output | 1 | Level-sensitive host interrupt |

## Verification
Two functions can meet in one cycle: a path's coalescing trigger setting the pending state, and a register write that clears it. The bench provokes this by driving a receive completion with a count threshold of 1 in the same cycle as a clear-bit write to host control, and again in the same cycle as a mailbox write of zero. After each edge it expects the line to be high, because the new completion must not be lost to a clear that was meant for the previous interrupt.

// File: rtl/coal_pkg.sv
package coal_pkg;

   // Register word addresses
   typedef enum logic [2:0] {
      A_HCTL = 3'd0,
      A_MASK = 3'd1,
      A_MBOX = 3'd2,
      A_RXTK = 3'd3,
      A_TXTK = 3'd4,
      A_RXCN = 3'd5,
      A_TXCN = 3'd6,
      A_OPT  = 3'd7
   } coal_addr_e;

   localparam int ADDR_W   = 3;
   // Host-control bit positions
   localparam int HC_STATE = 0;
   localparam int HC_CLR   = 1;
   localparam int HC_MASK  = 2;
   // Path indices
   localparam int P_RX     = 0;
   localparam int P_TX     = 1;
   localparam int N_PATHS  = 2;

endpackage

// File: rtl/coal_path.sv
module coal_path #(
   parameter int TICK_W = 16,
   parameter int CNT_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              evt_i,
   input  logic              tick_i,
   input  logic [TICK_W-1:0] tick_thr_i,
   input  logic [CNT_W-1:0]  cnt_thr_i,
   input  logic              cnt_en_i,
   output logic              fire_o
);

   logic              act_q;
   logic [TICK_W-1:0] tk_q, tk_n;
   logic [CNT_W-1:0]  ev_q, ev_n;
   logic              open_w, tk_hit, cnt_hit;

   always_comb begin
      tk_n    = (act_q && tick_i && tk_q != '1) ? tk_q + 1'b1 : tk_q;
      ev_n    = (evt_i && ev_q != '1) ? ev_q + 1'b1 : ev_q;
      open_w  = act_q | evt_i;
      tk_hit  = (tick_thr_i != '0) && (tk_n >= tick_thr_i);
      cnt_hit = cnt_en_i && (cnt_thr_i != '0) && (ev_n >= cnt_thr_i);
      fire_o  = open_w && (tk_hit || cnt_hit);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q <= 1'b0;
         tk_q  <= '0;
         ev_q  <= '0;
      end else if (fire_o) begin
         act_q <= 1'b0;
         tk_q  <= '0;
         ev_q  <= '0;
      end else if (open_w) begin
         act_q <= 1'b1;
         tk_q  <= tk_n;
         ev_q  <= ev_n;
      end
   end

endmodule

// File: rtl/coal_regs.sv
module coal_regs
   import coal_pkg::*;
#(
   parameter int DW          = 32,
   parameter int TICK_W      = 16,
   parameter int CNT_W       = 8,
   parameter int RX_TICK_DEF = 120,
   parameter int TX_TICK_DEF = 400,
   parameter int RX_CNT_DEF  = 25,
   parameter int TX_CNT_DEF  = 60
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             we_i,
   input  logic [ADDR_W-1:0]                addr_i,
   input  logic [DW-1:0]                    wdata_i,
   input  logic                             pend_i,
   output logic [DW-1:0]                    rdata_o,
   output logic [N_PATHS-1:0][TICK_W-1:0]   tick_thr_o,
   output logic [N_PATHS-1:0][CNT_W-1:0]    cnt_thr_o,
   output logic                             upd_only_o,
   output logic                             hc_mask_o,
   output logic                             msk_o,
   output logic                             mbox_nz_o,
   output logic                             clr_o
);

   logic [DW-1:0] mbox_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tick_thr_o[P_RX] <= TICK_W'(RX_TICK_DEF);
         tick_thr_o[P_TX] <= TICK_W'(TX_TICK_DEF);
         cnt_thr_o[P_RX]  <= CNT_W'(RX_CNT_DEF);
         cnt_thr_o[P_TX]  <= CNT_W'(TX_CNT_DEF);
         upd_only_o       <= 1'b0;
         hc_mask_o        <= 1'b0;
         msk_o            <= 1'b0;
         mbox_q           <= '0;
      end else if (we_i) begin
         case (coal_addr_e'(addr_i))
            A_HCTL: hc_mask_o        <= wdata_i[HC_MASK];
            A_MASK: msk_o            <= wdata_i[0];
            A_MBOX: mbox_q           <= wdata_i;
            A_RXTK: tick_thr_o[P_RX] <= wdata_i[TICK_W-1:0];
            A_TXTK: tick_thr_o[P_TX] <= wdata_i[TICK_W-1:0];
            A_RXCN: cnt_thr_o[P_RX]  <= wdata_i[CNT_W-1:0];
            A_TXCN: cnt_thr_o[P_TX]  <= wdata_i[CNT_W-1:0];
            A_OPT:  upd_only_o       <= wdata_i[0];
            default: ;
         endcase
      end
   end

   assign mbox_nz_o = (mbox_q != '0);
   assign clr_o     = we_i && ((coal_addr_e'(addr_i) == A_MBOX) ||
                      ((coal_addr_e'(addr_i) == A_HCTL) && wdata_i[HC_CLR]));

   always_comb begin
      rdata_o = '0;
      case (coal_addr_e'(addr_i))
         A_HCTL: begin
            rdata_o[HC_STATE] = pend_i;
            rdata_o[HC_MASK]  = hc_mask_o;
         end
         A_MASK: rdata_o[0]          = msk_o;
         A_MBOX: rdata_o             = mbox_q;
         A_RXTK: rdata_o[TICK_W-1:0] = tick_thr_o[P_RX];
         A_TXTK: rdata_o[TICK_W-1:0] = tick_thr_o[P_TX];
         A_RXCN: rdata_o[CNT_W-1:0]  = cnt_thr_o[P_RX];
         A_TXCN: rdata_o[CNT_W-1:0]  = cnt_thr_o[P_TX];
         A_OPT:  rdata_o[0]          = upd_only_o;
         default: ;
      endcase
   end

endmodule

// File: rtl/coal_irq_ctrl.sv
module coal_irq_ctrl
   import coal_pkg::*;
#(
   parameter int DW          = 32,
   parameter int TICK_W      = 16,
   parameter int CNT_W       = 8,
   parameter int RX_TICK_DEF = 120,
   parameter int TX_TICK_DEF = 400,
   parameter int RX_CNT_DEF  = 25,
   parameter int TX_CNT_DEF  = 60
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              tx_done_i,
   input  logic              rx_done_i,
   input  logic              reg_we_i,
   input  logic [ADDR_W-1:0] reg_addr_i,
   input  logic [DW-1:0]     reg_wdata_i,
   output logic [DW-1:0]     reg_rdata_o,
   output logic              irq_o
);

   localparam longint TICK_MAX = (64'd1 << TICK_W) - 1;
   localparam longint CNT_MAX  = (64'd1 << CNT_W) - 1;

   if (TICK_W > DW || CNT_W > DW || DW < 3) begin : g_bad_width
      $error("coal_irq_ctrl: field widths exceed register width");
   end
   if (RX_TICK_DEF > TICK_MAX || TX_TICK_DEF > TICK_MAX) begin : g_bad_tick
      $error("coal_irq_ctrl: tick default does not fit TICK_W");
   end
   if (RX_CNT_DEF > CNT_MAX || TX_CNT_DEF > CNT_MAX) begin : g_bad_cnt
      $error("coal_irq_ctrl: count default does not fit CNT_W");
   end

   logic [N_PATHS-1:0][TICK_W-1:0] tick_thr;
   logic [N_PATHS-1:0][CNT_W-1:0]  cnt_thr;
   logic [N_PATHS-1:0]             evt, hit, cnt_en;
   logic upd_only, hc_mask, msk, mbox_nz, clr, pend_q;

   assign evt[P_RX]    = rx_done_i;
   assign evt[P_TX]    = tx_done_i;
   assign cnt_en[P_RX] = 1'b1;
   assign cnt_en[P_TX] = ~upd_only;

   coal_regs #(
      .DW(DW), .TICK_W(TICK_W), .CNT_W(CNT_W),
      .RX_TICK_DEF(RX_TICK_DEF), .TX_TICK_DEF(TX_TICK_DEF),
      .RX_CNT_DEF(RX_CNT_DEF), .TX_CNT_DEF(TX_CNT_DEF)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
      .pend_i(pend_q), .rdata_o(reg_rdata_o),
      .tick_thr_o(tick_thr), .cnt_thr_o(cnt_thr), .upd_only_o(upd_only),
      .hc_mask_o(hc_mask), .msk_o(msk), .mbox_nz_o(mbox_nz), .clr_o(clr)
   );

   for (genvar g = 0; g < N_PATHS; g++) begin : g_path
      coal_path #(.TICK_W(TICK_W), .CNT_W(CNT_W)) u_path (
         .clk(clk), .rst_n(rst_n),
         .evt_i(evt[g]), .tick_i(tick_i),
         .tick_thr_i(tick_thr[g]), .cnt_thr_i(cnt_thr[g]),
         .cnt_en_i(cnt_en[g]), .fire_o(hit[g])
      );
   end

   // A fresh trigger beats a clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pend_q <= 1'b0;
      else if (|hit)   pend_q <= 1'b1;
      else if (clr)    pend_q <= 1'b0;
   end

   assign irq_o = pend_q && !hc_mask && !msk && !mbox_nz;

endmodule

// File: rtl/coal_irq_chk.sv
module coal_irq_chk
   import coal_pkg::*;
#(
   parameter int TICK_W = 16,
   parameter int CNT_W  = 8
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic                           irq_o,
   input logic                           pend_q,
   input logic [N_PATHS-1:0]             hit,
   input logic                           clr,
   input logic                           hc_mask,
   input logic                           msk,
   input logic                           mbox_nz,
   input logic [N_PATHS-1:0][TICK_W-1:0] tick_thr,
   input logic [N_PATHS-1:0][CNT_W-1:0]  cnt_thr
);

   // R11
   fire_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|hit) |=> pend_q);

   // R9
   clear_drops_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !(|hit)) |=> !pend_q);

   // R6
   hc_mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hc_mask |-> !irq_o);

   // R7
   mask_reg_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      msk |-> !irq_o);

   // R8
   mbox_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mbox_nz |-> !irq_o);

   // R6
   pend_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && !clr) |=> pend_q);

   // R4
   rx_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_thr[P_RX] == '0 && cnt_thr[P_RX] == '0) |-> !hit[P_RX]);

   // R4
   tx_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_thr[P_TX] == '0 && cnt_thr[P_TX] == '0) |-> !hit[P_TX]);

endmodule

bind coal_irq_ctrl coal_irq_chk #(.TICK_W(TICK_W), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .irq_o(irq_o), .pend_q(pend_q), .hit(hit),
   .clr(clr), .hc_mask(hc_mask), .msk(msk), .mbox_nz(mbox_nz),
   .tick_thr(tick_thr), .cnt_thr(cnt_thr)
);

// File: tb/coal_irq_ctrl_tb.sv
module coal_irq_ctrl_tb_top;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0, tx_done = 1'b0, rx_done = 1'b0;
   logic        we = 1'b0;
   logic [2:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq;
   int          checks = 0;
   int          errors = 0;
   bit          done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   coal_irq_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .tx_done_i(tx_done),
      .rx_done_i(rx_done), .reg_we_i(we), .reg_addr_i(addr),
      .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk); we = 1'b1; addr = a; wdata = d;
      @(posedge clk);
      @(negedge clk); we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk); addr = a; #1 d = rdata;
   endtask

   task automatic pulse_rx(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); rx_done = 1'b1; @(posedge clk); @(negedge clk); rx_done = 1'b0;
      end
   endtask

   task automatic pulse_tx(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); tx_done = 1'b1; @(posedge clk); @(negedge clk); tx_done = 1'b0;
      end
   endtask

   task automatic pulse_tick(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); tick = 1'b1; @(posedge clk); @(negedge clk); tick = 1'b0;
      end
   endtask

   task automatic t_reset();
      logic [31:0] d;
      check("R1 irq", {31'd0, irq}, 32'd0);
      rd(3'd3, d); check("R1 rx ticks", d, 32'd120);
      rd(3'd4, d); check("R1 tx ticks", d, 32'd400);
      rd(3'd5, d); check("R1 rx count", d, 32'd25);
      rd(3'd6, d); check("R1 tx count", d, 32'd60);
      rd(3'd0, d); check("R1 hctl", d, 32'd0);
      rd(3'd2, d); check("R1 mbox", d, 32'd0);
   endtask

   task automatic t_rx_count();
      logic [31:0] d;
      wr(3'd3, 0); wr(3'd5, 3);
      pulse_rx(2);
      check("R2 before Nth", {31'd0, irq}, 32'd0);
      pulse_rx(1);
      check("R2 at Nth", {31'd0, irq}, 32'd1);
      rd(3'd0, d); check("R10 state flag", {31'd0, d[0]}, 32'd1);
      wr(3'd0, 32'h2);
      check("R10 clear", {31'd0, irq}, 32'd0);
      rd(3'd0, d); check("R10 flag cleared", {31'd0, d[0]}, 32'd0);
   endtask

   task automatic t_rx_ticks();
      wr(3'd5, 0); wr(3'd3, 4);
      pulse_tick(3);
      check("R3 ticks idle ignored", {31'd0, irq}, 32'd0);
      pulse_rx(1);
      pulse_tick(3);
      check("R3 before T", {31'd0, irq}, 32'd0);
      pulse_tick(1);
      check("R3 at T", {31'd0, irq}, 32'd1);
      wr(3'd0, 32'h2);
   endtask

   task automatic t_tx_upd_only();
      wr(3'd7, 1); wr(3'd6, 2); wr(3'd4, 5);
      pulse_tx(3);
      check("R5 count ignored", {31'd0, irq}, 32'd0);
      pulse_tick(4);
      check("R5 before ticks", {31'd0, irq}, 32'd0);
      pulse_tick(1);
      check("R5 tick fires", {31'd0, irq}, 32'd1);
      wr(3'd0, 32'h2);
      wr(3'd7, 0);
      pulse_tx(2);
      check("R5 count active when off", {31'd0, irq}, 32'd1);
      wr(3'd0, 32'h2);
   endtask

   task automatic t_zero_off();
      logic [31:0] d;
      wr(3'd3, 0); wr(3'd5, 0);
      pulse_rx(10);
      pulse_tick(20);
      check("R4 no irq", {31'd0, irq}, 32'd0);
      rd(3'd0, d); check("R4 no pending", {31'd0, d[0]}, 32'd0);
      wr(3'd5, 3);
      @(negedge clk);
      check("R4 open window fires", {31'd0, irq}, 32'd1);
      wr(3'd0, 32'h2);
   endtask

   task automatic t_masks();
      logic [31:0] d;
      wr(3'd3, 0); wr(3'd5, 1);
      wr(3'd0, 32'h4);
      pulse_rx(1);
      check("R6 masked", {31'd0, irq}, 32'd0);
      rd(3'd0, d); check("R10 flag while masked", {31'd0, d[0]}, 32'd1);
      wr(3'd0, 32'h0);
      check("R6 raised on unmask", {31'd0, irq}, 32'd1);
      wr(3'd1, 32'h1);
      check("R7 masked", {31'd0, irq}, 32'd0);
      wr(3'd1, 32'h0);
      check("R7 raised on unmask", {31'd0, irq}, 32'd1);
      wr(3'd0, 32'h1);
      rd(3'd0, d); check("R10 bit0 write keeps pending", {31'd0, d[0]}, 32'd1);
      wr(3'd0, 32'h2);
      wr(3'd0, 32'h1);
      rd(3'd0, d); check("R10 bit0 write no set", {31'd0, d[0]}, 32'd0);
   endtask

   task automatic t_mailbox();
      logic [31:0] d;
      pulse_rx(1);
      check("R9 pending before", {31'd0, irq}, 32'd1);
      wr(3'd2, 32'h5);
      rd(3'd0, d); check("R9 nonzero write clears", {31'd0, d[0]}, 32'd0);
      pulse_rx(1);
      check("R8 mailbox masks", {31'd0, irq}, 32'd0);
      rd(3'd0, d); check("R8 pending kept", {31'd0, d[0]}, 32'd1);
      wr(3'd2, 32'h0);
      check("R9 zero write clears", {31'd0, irq}, 32'd0);
      rd(3'd0, d); check("R9 flag zero", {31'd0, d[0]}, 32'd0);
   endtask

   task automatic t_collide();
      @(negedge clk); rx_done = 1'b1; we = 1'b1; addr = 3'd0; wdata = 32'h2;
      @(posedge clk); @(negedge clk); rx_done = 1'b0; we = 1'b0;
      check("R11 fire beats clear bit", {31'd0, irq}, 32'd1);
      @(negedge clk); rx_done = 1'b1; we = 1'b1; addr = 3'd2; wdata = 32'h0;
      @(posedge clk); @(negedge clk); rx_done = 1'b0; we = 1'b0;
      check("R11 fire beats mailbox write", {31'd0, irq}, 32'd1);
      wr(3'd0, 32'h2);
      check("R10 clear after collide", {31'd0, irq}, 32'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_rx_count();
      t_rx_ticks();
      t_tx_upd_only();
      t_zero_off();
      t_masks();
      t_mailbox();
      t_collide();
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule